// File: doc/BRIEF.md
# Per-Byte Parity Sideband Formatter

This block sits on the write-data and read-data paths of a memory-mapped bus link. It does its work inside the per-byte user sideband. Each data byte owns a slot of 0 to 4 user bits. A parity bit for that byte, when one is present, always occupies the lowest bit of the slot. Each side of the link has its own parity setting: none, even or odd. The "near" side is the one facing the bus initiator, and the "far" side faces the target. The write path runs from near to far and the read path runs from far to near.

On each path the block compares the in-bound setting with the out-bound setting and picks one of four actions for every byte lane:
- Generate a parity bit and push the other user bits up by one.
- Remove the parity bit and pull the other user bits down by one.
- Forward the parity bit unchanged.
- Forward the parity bit inverted.

Data bytes always pass straight through. The whole transformation is combinational, so the handshake timing of the link is not changed.

Top module: `sbf_parity_fmt`

## Requirements
- R1: When the in-bound side of a path has no parity and the out-bound side has parity, the block places a parity bit in bit 0 of every byte's out-bound user slot. Bit k of the in-bound slot moves to bit k+1. Even parity is the XOR of the eight data bits, and odd parity is the inverse of that XOR.
- R2: When the in-bound side has parity and the out-bound side has none, bit 0 of every in-bound slot is dropped and bit k+1 moves to bit k.
- R3: When both sides use the same polarity, every user bit is forwarded unchanged, even a parity bit that does not match its data.
- R4: When the sides use opposite polarities, bit 0 of every slot is inverted and the other bits are forwarded unchanged. A parity bit that does not match its data is inverted as well.
- R5: When neither side has parity, every user bit is forwarded unchanged.
- R6: The write path takes the near-side setting as in-bound and the far-side setting as out-bound. The read path takes the far-side setting as in-bound and the near-side setting as out-bound. An out-bound slot is one bit wider than the in-bound slot when generating, one bit narrower when stripping, and the same width otherwise.
- R7: Write data and read data leave the block equal to the data that entered it.
- R8: A user field whose slot width is zero is carried on a single-bit port. On an output this bit is driven 0, and on an input this bit has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| nr_wdata | input | DATA_W | Write data from the near side |
| nr_wuser | input | max(1, NR_WBPB*DATA_W/8) | Write user slots from the near side |
| fr_wdata | output | DATA_W | Write data toward the far side |
| fr_wuser | output | max(1, out-bound write slot * DATA_W/8) | Write user slots toward the far side |
| fr_rdata | input | DATA_W | Read data from the far side |
| fr_ruser | input | max(1, FR_RBPB*DATA_W/8) | Read user slots from the far side |
| nr_rdata | output | DATA_W | Read data toward the near side |
| nr_ruser | output | max(1, out-bound read slot * DATA_W/8) | Read user slots toward the near side |

## Verification
The lane checks only apply while the data and user inputs are fully known. They also assume that any in-bound slot configured to carry parity is at least one bit wide, which elaboration enforces. The stimulus drives every input to a defined value in every cycle. It uses all-zero, all-one, alternating and random patterns, so parity bits that match and bits that do not match both reach the pass and invert paths. Five parameter sets cover every action on both paths. Two of these sets include zero-width user slots.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2
   } par_kind_e;

   typedef enum logic [1:0] {
      XF_PASS  = 2'd0,
      XF_GEN   = 2'd1,
      XF_STRIP = 2'd2,
      XF_FLIP  = 2'd3
   } xform_e;

   function automatic xform_e pick_xform(par_kind_e in_k, par_kind_e out_k);
      if (in_k == PAR_NONE && out_k != PAR_NONE) return XF_GEN;
      if (in_k != PAR_NONE && out_k == PAR_NONE) return XF_STRIP;
      if (in_k != PAR_NONE && in_k != out_k)     return XF_FLIP;
      return XF_PASS;
   endfunction

   function automatic int out_bpb(int ib, par_kind_e in_k, par_kind_e out_k);
      case (pick_xform(in_k, out_k))
         XF_GEN:   return ib + 1;
         XF_STRIP: return ib - 1;
         default:  return ib;
      endcase
   endfunction

   function automatic int port_w(int w);
      return (w < 1) ? 1 : w;
   endfunction

endpackage

// File: rtl/sbf_lane.sv
module sbf_lane #(
   parameter sbf_pkg::xform_e XF = sbf_pkg::XF_PASS,
   parameter int IB = 1,
   parameter int OB = 1,
   parameter bit HAS_PAR = 1'b0,
   parameter bit IN_ODD = 1'b0,
   parameter bit OUT_ODD = 1'b0
) (
   input  logic [7:0]                      byte_in,
   input  logic [sbf_pkg::port_w(IB)-1:0]  slot_in,
   output logic [sbf_pkg::port_w(OB)-1:0]  slot_out
);

   generate
      case (XF)
         sbf_pkg::XF_GEN: begin : g_gen
            logic par_bit;
            assign par_bit = (^byte_in) ^ OUT_ODD;
            if (IB == 0) begin : g_empty
               logic unused_slot;
               assign unused_slot = ^slot_in;
               assign slot_out = par_bit;
            end else begin : g_shift
               assign slot_out = {slot_in[IB-1:0], par_bit};
               always_comb begin
                  if (!$isunknown({byte_in, slot_in})) begin
                     // R1
                     gen_shift_chk: assert (slot_out[OB-1:1] == slot_in)
                        else $error("user bits not moved up over parity");
                  end
               end
            end
            always_comb begin
               if (!$isunknown(byte_in)) begin
                  // R1
                  gen_parity_chk: assert ((^{byte_in, slot_out[0]}) == OUT_ODD)
                     else $error("generated parity has wrong polarity");
               end
            end
         end
         sbf_pkg::XF_STRIP: begin : g_strip
            logic unused_strip;
            assign unused_strip = (^byte_in) ^ slot_in[0];
            if (OB == 0) begin : g_empty
               assign slot_out = 1'b0;
            end else begin : g_shift
               assign slot_out = slot_in[IB-1:1];
               always_comb begin
                  if (!$isunknown(slot_in)) begin
                     // R2
                     strip_align_chk: assert ({slot_out, 1'b0} == {slot_in[IB-1:1], 1'b0})
                        else $error("stripped slot misaligned");
                  end
               end
            end
         end
         sbf_pkg::XF_FLIP: begin : g_flip
            if (IB == 1) begin : g_one
               assign slot_out = ~slot_in[0];
            end else begin : g_many
               assign slot_out = {slot_in[IB-1:1], ~slot_in[0]};
            end
            always_comb begin
               if (!$isunknown({byte_in, slot_in})) begin
                  // R4
                  flip_keep_chk: assert ((((^{byte_in, slot_in[0]}) == IN_ODD))
                                         == (((^{byte_in, slot_out[0]}) == OUT_ODD)))
                     else $error("inverted parity changed its validity");
               end
            end
         end
         default: begin : g_pass
            logic unused_byte;
            assign unused_byte = ^byte_in;
            if (IB == 0) begin : g_empty
               logic unused_slot;
               assign unused_slot = ^slot_in;
               assign slot_out = 1'b0;
            end else begin : g_copy
               assign slot_out = slot_in;
               if (HAS_PAR) begin : g_chk
                  always_comb begin
                     if (!$isunknown({byte_in, slot_in})) begin
                        // R3
                        same_keep_chk: assert ((((^{byte_in, slot_in[0]}) == IN_ODD))
                                               == (((^{byte_in, slot_out[0]}) == OUT_ODD)))
                           else $error("forwarded parity changed its validity");
                     end
                  end
               end
            end
         end
      endcase
   endgenerate

endmodule

// File: rtl/sbf_path.sv
module sbf_path #(
   parameter sbf_pkg::par_kind_e IN_PAR = sbf_pkg::PAR_NONE,
   parameter sbf_pkg::par_kind_e OUT_PAR = sbf_pkg::PAR_NONE,
   parameter int LANES = 4,
   parameter int IB = 1,
   localparam int OB = sbf_pkg::out_bpb(IB, IN_PAR, OUT_PAR),
   localparam int IW = sbf_pkg::port_w(IB * LANES),
   localparam int OW = sbf_pkg::port_w(OB * LANES)
) (
   input  logic [8*LANES-1:0] data_in,
   input  logic [IW-1:0]      user_in,
   output logic [8*LANES-1:0] data_out,
   output logic [OW-1:0]      user_out
);

   localparam sbf_pkg::xform_e XF = sbf_pkg::pick_xform(IN_PAR, OUT_PAR);
   localparam bit IN_ODD  = (IN_PAR == sbf_pkg::PAR_ODD);
   localparam bit OUT_ODD = (OUT_PAR == sbf_pkg::PAR_ODD);
   localparam bit HAS_PAR = (IN_PAR != sbf_pkg::PAR_NONE);

   assign data_out = data_in;

   logic [sbf_pkg::port_w(OB)-1:0] lane_out [LANES];

   generate
      if (IB == 0) begin : g_no_in
         logic unused_in;
         assign unused_in = ^user_in;
      end
      if (OB == 0) begin : g_no_out
         assign user_out = '0;
      end

      for (genvar l = 0; l < LANES; l++) begin : g_lane
         logic [sbf_pkg::port_w(IB)-1:0] slot;
         if (IB == 0) begin : g_tie
            assign slot = 1'b0;
         end else begin : g_slice
            assign slot = user_in[l*IB +: IB];
         end

         sbf_lane #(
            .XF      (XF),
            .IB      (IB),
            .OB      (OB),
            .HAS_PAR (HAS_PAR),
            .IN_ODD  (IN_ODD),
            .OUT_ODD (OUT_ODD)
         ) i_lane (
            .byte_in  (data_in[8*l +: 8]),
            .slot_in  (slot),
            .slot_out (lane_out[l])
         );

         if (OB == 0) begin : g_drop
            logic unused_lane;
            assign unused_lane = ^lane_out[l];
         end else begin : g_place
            assign user_out[l*OB +: OB] = lane_out[l];
         end
      end
   endgenerate

endmodule

// File: rtl/sbf_parity_fmt.sv
module sbf_parity_fmt #(
   parameter int DATA_W = 32,
   parameter sbf_pkg::par_kind_e NR_PAR = sbf_pkg::PAR_NONE,
   parameter sbf_pkg::par_kind_e FR_PAR = sbf_pkg::PAR_EVEN,
   parameter int NR_WBPB = 1,
   parameter int FR_RBPB = 2,
   localparam int LANES = DATA_W / 8,
   localparam int FR_WBPB = sbf_pkg::out_bpb(NR_WBPB, NR_PAR, FR_PAR),
   localparam int NR_RBPB = sbf_pkg::out_bpb(FR_RBPB, FR_PAR, NR_PAR)
) (
   input  logic [DATA_W-1:0]                          nr_wdata,
   input  logic [sbf_pkg::port_w(NR_WBPB*LANES)-1:0]  nr_wuser,
   output logic [DATA_W-1:0]                          fr_wdata,
   output logic [sbf_pkg::port_w(FR_WBPB*LANES)-1:0]  fr_wuser,
   input  logic [DATA_W-1:0]                          fr_rdata,
   input  logic [sbf_pkg::port_w(FR_RBPB*LANES)-1:0]  fr_ruser,
   output logic [DATA_W-1:0]                          nr_rdata,
   output logic [sbf_pkg::port_w(NR_RBPB*LANES)-1:0]  nr_ruser
);

   generate
      if (DATA_W < 32 || DATA_W > 1024 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
         $error("DATA_W must be a power of two between 32 and 1024");
      end
      if (NR_WBPB < 0 || NR_WBPB > 4 || FR_WBPB < 0 || FR_WBPB > 4) begin : g_bad_wslot
         $error("write user slot must hold 0 to 4 bits per byte on both sides");
      end
      if (FR_RBPB < 0 || FR_RBPB > 4 || NR_RBPB < 0 || NR_RBPB > 4) begin : g_bad_rslot
         $error("read user slot must hold 0 to 4 bits per byte on both sides");
      end
      if (NR_PAR != sbf_pkg::PAR_NONE && NR_WBPB < 1) begin : g_bad_nr
         $error("near side carries parity but its write slot is empty");
      end
      if (FR_PAR != sbf_pkg::PAR_NONE && FR_RBPB < 1) begin : g_bad_fr
         $error("far side carries parity but its read slot is empty");
      end
   endgenerate

   // R6: write path runs near to far
   sbf_path #(
      .IN_PAR  (NR_PAR),
      .OUT_PAR (FR_PAR),
      .LANES   (LANES),
      .IB      (NR_WBPB)
   ) i_wpath (
      .data_in  (nr_wdata),
      .user_in  (nr_wuser),
      .data_out (fr_wdata),
      .user_out (fr_wuser)
   );

   // R6: read path runs far to near
   sbf_path #(
      .IN_PAR  (FR_PAR),
      .OUT_PAR (NR_PAR),
      .LANES   (LANES),
      .IB      (FR_RBPB)
   ) i_rpath (
      .data_in  (fr_rdata),
      .user_in  (fr_ruser),
      .data_out (nr_rdata),
      .user_out (nr_ruser)
   );

   always_comb begin
      if (!$isunknown({nr_wdata, fr_rdata})) begin
         // R7
         data_thru_chk: assert (fr_wdata == nr_wdata && nr_rdata == fr_rdata)
            else $error("data altered between sides");
      end
   end

endmodule

// File: tb/test_sbf_parity_fmt.sv
module test_sbf_parity_fmt;
   import sbf_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic [31:0] wd, rd;
   logic [15:0] uw, ur;

   // D0: near none / far even, near write slot 1, far read slot 2
   logic [31:0] d0_wdo, d0_rdo;
   logic [7:0]  d0_wuo;
   logic [3:0]  d0_ruo;
   sbf_parity_fmt #(.DATA_W(32), .NR_PAR(PAR_NONE), .FR_PAR(PAR_EVEN),
                    .NR_WBPB(1), .FR_RBPB(2)) i_sbf_parity_fmt (
      .nr_wdata(wd), .nr_wuser(uw[3:0]), .fr_wdata(d0_wdo), .fr_wuser(d0_wuo),
      .fr_rdata(rd), .fr_ruser(ur[7:0]), .nr_rdata(d0_rdo), .nr_ruser(d0_ruo));

   // D1: near odd / far none, near write slot 3, far read slot 0
   logic [31:0] d1_wdo, d1_rdo;
   logic [7:0]  d1_wuo;
   logic [3:0]  d1_ruo;
   sbf_parity_fmt #(.DATA_W(32), .NR_PAR(PAR_ODD), .FR_PAR(PAR_NONE),
                    .NR_WBPB(3), .FR_RBPB(0)) i_d1 (
      .nr_wdata(wd), .nr_wuser(uw[11:0]), .fr_wdata(d1_wdo), .fr_wuser(d1_wuo),
      .fr_rdata(rd), .fr_ruser(ur[0:0]), .nr_rdata(d1_rdo), .nr_ruser(d1_ruo));

   // D2: near even / far odd, slots 2 and 1
   logic [31:0] d2_wdo, d2_rdo;
   logic [7:0]  d2_wuo;
   logic [3:0]  d2_ruo;
   sbf_parity_fmt #(.DATA_W(32), .NR_PAR(PAR_EVEN), .FR_PAR(PAR_ODD),
                    .NR_WBPB(2), .FR_RBPB(1)) i_d2 (
      .nr_wdata(wd), .nr_wuser(uw[7:0]), .fr_wdata(d2_wdo), .fr_wuser(d2_wuo),
      .fr_rdata(rd), .fr_ruser(ur[3:0]), .nr_rdata(d2_rdo), .nr_ruser(d2_ruo));

   // D3: odd on both sides, slots 1 and 4
   logic [31:0] d3_wdo, d3_rdo;
   logic [3:0]  d3_wuo;
   logic [15:0] d3_ruo;
   sbf_parity_fmt #(.DATA_W(32), .NR_PAR(PAR_ODD), .FR_PAR(PAR_ODD),
                    .NR_WBPB(1), .FR_RBPB(4)) i_d3 (
      .nr_wdata(wd), .nr_wuser(uw[3:0]), .fr_wdata(d3_wdo), .fr_wuser(d3_wuo),
      .fr_rdata(rd), .fr_ruser(ur[15:0]), .nr_rdata(d3_rdo), .nr_ruser(d3_ruo));

   // D4: no parity anywhere, slots 0 and 3
   logic [31:0] d4_wdo, d4_rdo;
   logic [0:0]  d4_wuo;
   logic [11:0] d4_ruo;
   sbf_parity_fmt #(.DATA_W(32), .NR_PAR(PAR_NONE), .FR_PAR(PAR_NONE),
                    .NR_WBPB(0), .FR_RBPB(3)) i_d4 (
      .nr_wdata(wd), .nr_wuser(uw[0:0]), .fr_wdata(d4_wdo), .fr_wuser(d4_wuo),
      .fr_rdata(rd), .fr_ruser(ur[11:0]), .nr_rdata(d4_rdo), .nr_ruser(d4_ruo));

   // parity codes: 0 none, 1 even, 2 odd
   function automatic int ref_ob(int ib, int ip, int op);
      if (ip == 0 && op != 0) return ib + 1;
      if (ip != 0 && op == 0) return ib - 1;
      return ib;
   endfunction

   function automatic logic [19:0] ref_user(logic [31:0] d, logic [15:0] u,
                                            int ib, int ip, int op);
      logic [19:0] res = '0;
      int ob = ref_ob(ib, ip, op);
      for (int l = 0; l < 4; l++) begin
         logic [7:0] b = d[8*l +: 8];
         logic p = ^b;
         if (op == 2) p = ~p;
         for (int k = 0; k < ob; k++) begin
            logic v;
            if (ip == 0 && op != 0)      v = (k == 0) ? p : u[l*ib + k - 1];
            else if (ip != 0 && op == 0) v = u[l*ib + k + 1];
            else if (ip != op && k == 0) v = ~u[l*ib];
            else                         v = u[l*ib + k];
            res[l*ob + k] = v;
         end
      end
      return res;
   endfunction

   task automatic check_user(string tag, logic [19:0] act, logic [19:0] exp, int w);
      logic [19:0] m = (20'd1 << w) - 20'd1;
      checks++;
      if ((act & m) !== (exp & m)) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act & m, exp & m);
      end
   endtask

   task automatic check_data(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_all();
      logic [15:0] ur0 = 16'h0;
      check_user("R1/R6 d0 write gen even", 20'(d0_wuo), ref_user(wd, uw, 1, 0, 1), 8);
      check_user("R2/R6 d0 read strip", 20'(d0_ruo), ref_user(rd, ur, 2, 1, 0), 4);
      check_user("R2/R6 d1 write strip", 20'(d1_wuo), ref_user(wd, uw, 3, 2, 0), 8);
      check_user("R1/R8 d1 read gen odd from empty slot", 20'(d1_ruo),
                 ref_user(rd, ur0, 0, 0, 2), 4);
      check_user("R4 d2 write invert", 20'(d2_wuo), ref_user(wd, uw, 2, 1, 2), 8);
      check_user("R4 d2 read invert", 20'(d2_ruo), ref_user(rd, ur, 1, 2, 1), 4);
      check_user("R3 d3 write same", 20'(d3_wuo), ref_user(wd, uw, 1, 2, 2), 4);
      check_user("R3 d3 read same", 20'(d3_ruo), ref_user(rd, ur, 4, 2, 2), 16);
      check_user("R8 d4 empty write slot drives 0", 20'(d4_wuo), 20'h0, 1);
      check_user("R5 d4 read no parity", 20'(d4_ruo), ref_user(rd, ur, 3, 0, 0), 12);
      check_data("R7 d0 wdata", d0_wdo, wd);
      check_data("R7 d0 rdata", d0_rdo, rd);
      check_data("R7 d1 wdata", d1_wdo, wd);
      check_data("R7 d2 rdata", d2_rdo, rd);
      check_data("R7 d3 wdata", d3_wdo, wd);
      check_data("R7 d4 rdata", d4_rdo, rd);
   endtask

   task automatic apply(logic [31:0] a, logic [31:0] b, logic [15:0] c, logic [15:0] e);
      @(posedge clk);
      #1;
      wd = a; rd = b; uw = c; ur = e;
      @(negedge clk);
      check_all();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected<20000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      wd = '0; rd = '0; uw = '0; ur = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset-state style check: all-zero inputs
      @(negedge clk);
      check_user("R1 zero data even parity", 20'(d0_wuo), 20'h0, 8);
      check_user("R1 zero data odd parity", 20'(d1_ruo), 20'hF, 4);
      check_all();
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 16'hFFFF);
      apply(32'hA5A5_5A5A, 32'h0102_0408, 16'hAAAA, 16'h5555);
      apply(32'h0000_0001, 32'h8000_0000, 16'h0001, 16'h8000);
      // R8: toggling empty write slot input leaves outputs alone
      apply(32'h1234_5678, 32'h9ABC_DEF0, 16'h0000, 16'h0000);
      apply(32'h1234_5678, 32'h9ABC_DEF0, 16'h0001, 16'h0001);
      check_user("R8 d4 empty input slot ignored", 20'(d4_wuo), 20'h0, 1);
      check_user("R8 d1 read unaffected by empty slot bit", 20'(d1_ruo),
                 ref_user(32'h9ABC_DEF0, 16'h0, 0, 0, 2), 4);
      for (int i = 0; i < 300; i++) begin
         apply($urandom, $urandom, 16'($urandom), 16'($urandom));
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule